// File: doc/BRIEF.md
# Supply Lockout and Burst-Restart Sequencer

This block is the supervisory controller of an off-line switching regulator. It watches two digital comparator flags on the chip supply: one says the supply is above the upper threshold and one says it is below the lower threshold. It also watches a flag that reports excess current in the supply limiter, which signals an open optocoupler, and a digital junction temperature code. From these it drives two outputs. One enables the high-voltage start-up charging current. The other enables switching and feeds the PWM generator.

After power-on the block holds switching off and charges the supply capacitor. Switching starts once the supply reaches the upper threshold, and it continues as long as the supply stays above the lower threshold. A fault is either a supply collapse below the lower threshold or an open-optocoupler report. A fault starts a counted burst restart. Start-up charging is switched on and off in step with the supply thresholds, so the supply capacitor cycles between the two thresholds. Each arrival at the upper threshold advances a counter, and switching is retried only on the eighth arrival. An over-temperature hysteresis compare gates the switching enable and does nothing else.

Top module: `uvlo_restart_seq`

## Requirements
- R1: After reset, and until the filtered supply flag first reports above-upper, charge_en_o is 1 and switch_en_o is 0. A supply between the thresholds does not start switching.
- R2: When the filtered above-upper flag asserts in lockout, switching turns on and charging turns off. Switching then stays on while the supply is between the two thresholds.
- R3: Each comparator input must hold a new value for FILT_CYCLES consecutive clocks before the block acts on it. A pulse shorter than that has no effect.
- R4: If the filtered below-lower flag asserts while switching, switching stops and charging turns on. This starts a restart sequence with the counter cleared.
- R5: During a restart, each filtered above-upper arrival while charging increments the counter. For counts below RESTART_CYCLES (8), that arrival turns charging off and keeps switching off. A filtered below-lower report then turns charging back on.
- R6: On the RESTART_CYCLES-th upper-threshold arrival of a restart, switching resumes and charging turns off.
- R7: A filtered limiter-overcurrent flag (1 = limiter current above its trip) while switching stops switching. It enters the same counted restart with charging off until the supply falls below the lower threshold. If the flag is still set when switching resumes, the restart repeats. If it has cleared, switching continues.
- R8: The over-temperature state sets when temp_code_i >= TEMP_TRIP (140) and clears when temp_code_i < TEMP_CLEAR (110). It keeps its value in between. While set, it forces switch_en_o to 0 and does not change charge_en_o or the sequencer state.
- R9: charge_en_o and switch_en_o are never 1 at the same time, and the restart counter never exceeds RESTART_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on reset) |
| sup_above_hi_i | input | 1 | Supply above upper threshold comparator flag |
| sup_below_lo_i | input | 1 | Supply below lower threshold comparator flag |
| limiter_ovc_i | input | 1 | Limiter overcurrent flag, open-optocoupler indication |
| temp_code_i | input | TEMP_W | Junction temperature in degrees |
| charge_en_o | output | 1 | Start-up charging current enable |
| switch_en_o | output | 1 | Switching enable to the PWM generator |

## Verification
The hardest situation to reach is the eighth restart charge while the optocoupler fault is still present. At that point switching must resume for a moment and then collapse into a fresh restart. The stimulus reaches it by modelling the supply as three threshold levels. It drives a full hold-off of eight charge and discharge cycles with the limiter flag held high, then repeats the hold-off after the flag is released. The thermal hysteresis is covered by sweeping every temperature code up and then down while the block is switching.

// File: rtl/uvlo_seq_pkg.sv
package uvlo_seq_pkg;
  typedef enum logic [1:0] {
    ST_LOCKOUT  = 2'd0,
    ST_RUN      = 2'd1,
    ST_HOLD_CHG = 2'd2,
    ST_HOLD_DIS = 2'd3
  } seq_state_e;

  localparam int unsigned FLAG_ABOVE = 0;
  localparam int unsigned FLAG_BELOW = 1;
  localparam int unsigned FLAG_OVC   = 2;
  localparam int unsigned NUM_FLAGS  = 3;
endpackage

// File: rtl/flag_debounce.sv
module flag_debounce #(
  parameter int unsigned STABLE_CYCLES = 4,
  parameter bit          RST_VAL       = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  logic filt_q;

  generate
    if (STABLE_CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) filt_q <= RST_VAL;
        else         filt_q <= raw_i;
      end
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(STABLE_CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          filt_q <= RST_VAL;
          cnt_q  <= '0;
        end else if (raw_i == filt_q) begin
          cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
          filt_q <= raw_i;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end

      // R3: a change of the filtered flag follows a raw value of the same level
      a_r3_filter_follows_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(filt_q) |-> (filt_q == $past(raw_i)));
    end
  endgenerate

  assign filt_o = filt_q;
endmodule

// File: rtl/thermal_hyst.sv
module thermal_hyst #(
  parameter int unsigned TEMP_W     = 8,
  parameter int unsigned TEMP_TRIP  = 140,
  parameter int unsigned TEMP_CLEAR = 110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TRIP_C  = TEMP_W'(TEMP_TRIP);
  localparam logic [TEMP_W-1:0] CLEAR_C = TEMP_W'(TEMP_CLEAR);
  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hot_q <= 1'b0;
    else if (temp_code_i >= TRIP_C)  hot_q <= 1'b1;
    else if (temp_code_i < CLEAR_C)  hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  a_r8_trip_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_code_i >= TRIP_C) |=> hot_q);
  a_r8_clear_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_code_i < CLEAR_C) |=> !hot_q);
  a_r8_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_code_i >= CLEAR_C && temp_code_i < TRIP_C) |=> $stable(hot_q));
endmodule

// File: rtl/restart_fsm.sv
module restart_fsm
  import uvlo_seq_pkg::*;
#(
  parameter int unsigned RESTART_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic ovc_i,
  output logic charge_o,
  output logic run_o
);
  localparam int unsigned CNT_W = $clog2(RESTART_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_CYCLES);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_LOCKOUT: begin
        if (above_hi_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (below_lo_i) begin
          state_d = ST_HOLD_CHG;
          cnt_d   = '0;
        end else if (ovc_i) begin
          state_d = ST_HOLD_DIS;
          cnt_d   = '0;
        end
      end
      ST_HOLD_CHG: begin
        if (above_hi_i) begin
          if (cnt_inc == CNT_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            state_d = ST_HOLD_DIS;
            cnt_d   = cnt_inc;
          end
        end
      end
      ST_HOLD_DIS: begin
        if (below_lo_i) state_d = ST_HOLD_CHG;
      end
      default: state_d = ST_LOCKOUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKOUT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign charge_o = (state_q == ST_LOCKOUT) || (state_q == ST_HOLD_CHG);
  assign run_o    = (state_q == ST_RUN);

  a_r9_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_LAST);
  a_r2_run_needs_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(above_hi_i));
  a_r4_collapse_to_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && below_lo_i) |=> (state_q == ST_HOLD_CHG && cnt_q == '0));
  a_r7_ovc_to_discharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !below_lo_i && ovc_i) |=> (state_q == ST_HOLD_DIS));
  a_r6_retry_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_HOLD_CHG && state_q == ST_RUN) |-> ($past(cnt_q) == CNT_LAST - 1'b1));
endmodule

// File: rtl/uvlo_restart_seq.sv
module uvlo_restart_seq
  import uvlo_seq_pkg::*;
#(
  parameter int unsigned FILT_CYCLES    = 4,
  parameter int unsigned RESTART_CYCLES = 8,
  parameter int unsigned TEMP_W         = 8,
  parameter int unsigned TEMP_TRIP      = 140,
  parameter int unsigned TEMP_CLEAR     = 110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_above_hi_i,
  input  logic              sup_below_lo_i,
  input  logic              limiter_ovc_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              charge_en_o,
  output logic              switch_en_o
);
  // reset levels: supply assumed low at power-on
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1 << FLAG_BELOW);

  logic [NUM_FLAGS-1:0] raw_flags, filt_flags;
  logic hot, charge, run;

  always_comb begin
    raw_flags             = '0;
    raw_flags[FLAG_ABOVE] = sup_above_hi_i;
    raw_flags[FLAG_BELOW] = sup_below_lo_i;
    raw_flags[FLAG_OVC]   = limiter_ovc_i;
  end

  generate
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
      flag_debounce #(
        .STABLE_CYCLES (FILT_CYCLES),
        .RST_VAL       (FLAG_RST[g])
      ) i_flt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (raw_flags[g]),
        .filt_o (filt_flags[g])
      );
    end
  endgenerate

  thermal_hyst #(
    .TEMP_W     (TEMP_W),
    .TEMP_TRIP  (TEMP_TRIP),
    .TEMP_CLEAR (TEMP_CLEAR)
  ) i_therm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .temp_code_i (temp_code_i),
    .hot_o       (hot)
  );

  restart_fsm #(
    .RESTART_CYCLES (RESTART_CYCLES)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .above_hi_i (filt_flags[FLAG_ABOVE]),
    .below_lo_i (filt_flags[FLAG_BELOW]),
    .ovc_i      (filt_flags[FLAG_OVC]),
    .charge_o   (charge),
    .run_o      (run)
  );

  assign charge_en_o = charge;
  assign switch_en_o = run & ~hot;

  a_r9_exclusive_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(charge_en_o && switch_en_o));
  a_r8_hot_blocks_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot |-> !switch_en_o);
endmodule

// File: tb/test_uvlo_restart_seq.sv
module test_uvlo_restart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 3;
  localparam int NRST       = 8;
  localparam int TW         = 8;
  localparam int TRIP       = 140;
  localparam int CLR        = 110;
  localparam int SETTLE     = FILT + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above = 1'b0, below = 1'b1, ovc = 1'b0;
  logic [TW-1:0] temp = '0;
  logic charge, sw;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uvlo_restart_seq #(
    .FILT_CYCLES(FILT), .RESTART_CYCLES(NRST), .TEMP_W(TW),
    .TEMP_TRIP(TRIP), .TEMP_CLEAR(CLR)
  ) i_uvlo_restart_seq (
    .clk_i(clk), .rst_ni(rst_n), .sup_above_hi_i(above), .sup_below_lo_i(below),
    .limiter_ovc_i(ovc), .temp_code_i(temp), .charge_en_o(charge), .switch_en_o(sw)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic exp_chg, input logic exp_sw);
    checks++;
    if (charge !== exp_chg || sw !== exp_sw) begin
      errors++;
      $display("FAIL %s: charge=%b switch=%b expected charge=%b switch=%b",
               req, charge, sw, exp_chg, exp_sw);
    end
  endtask

  // supply level: 0 below lower, 1 between thresholds, 2 above upper
  task automatic supply(input int lvl);
    above = (lvl == 2);
    below = (lvl == 0);
    wait_cyc(SETTLE);
  endtask

  task automatic restart_cycles(input string req, input bit ovc_held);
    for (int k = 1; k <= NRST; k++) begin
      supply(2);
      if (k < NRST) begin
        expect_out(req, 1'b0, 1'b0);
        supply(1);
        expect_out(req, 1'b0, 1'b0);
        supply(0);
        expect_out(req, 1'b1, 1'b0);
      end else if (!ovc_held) begin
        expect_out("R6", 1'b0, 1'b1);
      end else begin
        expect_out("R7 repeat", 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    wait_cyc(3);
    expect_out("R1 reset", 1'b1, 1'b0);
    rst_n = 1'b1;
    wait_cyc(2);
    expect_out("R1", 1'b1, 1'b0);
    supply(1);
    expect_out("R1 mid", 1'b1, 1'b0);

    // R3: short pulse to upper is ignored
    above = 1'b1; wait_cyc(FILT - 1); above = 1'b0;
    wait_cyc(SETTLE);
    expect_out("R3 short upper", 1'b1, 1'b0);

    // R3: exact timing of acceptance
    above = 1'b1; wait_cyc(FILT);
    expect_out("R3 not yet", 1'b1, 1'b0);
    wait_cyc(1);
    expect_out("R2 start", 1'b0, 1'b1);
    wait_cyc(SETTLE);
    supply(1);
    expect_out("R2 mid run", 1'b0, 1'b1);

    below = 1'b1; wait_cyc(FILT - 1); below = 1'b0;
    wait_cyc(SETTLE);
    expect_out("R3 short lower", 1'b0, 1'b1);

    // R8 sweep up then down
    begin
      logic hot_m = 1'b0;
      for (int t = 0; t < 256; t++) begin
        temp = TW'(t); wait_cyc(2);
        if (t >= TRIP) hot_m = 1'b1; else if (t < CLR) hot_m = 1'b0;
        expect_out("R8 up", 1'b0, !hot_m);
      end
      for (int t = 255; t >= 0; t--) begin
        temp = TW'(t); wait_cyc(2);
        if (t >= TRIP) hot_m = 1'b1; else if (t < CLR) hot_m = 1'b0;
        expect_out("R8 down", 1'b0, !hot_m);
      end
    end
    temp = 8'd25; wait_cyc(2);

    // R4/R5/R6: supply collapse
    supply(0);
    expect_out("R4", 1'b1, 1'b0);
    restart_cycles("R5", 1'b0);
    supply(1);
    expect_out("R6 stays", 1'b0, 1'b1);

    // R7: optocoupler fault held through one retry
    ovc = 1'b1; wait_cyc(SETTLE);
    expect_out("R7 entry", 1'b0, 1'b0);
    supply(0);
    expect_out("R7 charge", 1'b1, 1'b0);
    restart_cycles("R7", 1'b1);
    ovc = 1'b0;
    supply(1);
    expect_out("R7 discharge", 1'b0, 1'b0);
    supply(0);
    restart_cycles("R7 cleared", 1'b0);
    supply(1);
    expect_out("R7 recovered", 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule